// File: doc/BRIEF.md
# Single-Bus Accumulator-Free CPU Datapath

This block is the execute core of a very small processor in which every data movement passes over one shared bus. The bus is a register: each instruction either writes a new value into it, clears it, or leaves it as it was. A 5-bit instruction arrives on a valid/ready stream input and is executed on the clock edge where it is accepted. The low bits of the instruction pick a register, an ALU operation or a one-bit immediate.

Values move between a bank of four general registers, two ALU operand latches (A and B) and the bus. The ALU always works on the two latches. Its adder is a ripple-carry chain. Arithmetic results are also summarised in a carry flag. Wider constants are built by program: the program loads the immediate 1, then shifts and adds it. The instruction source, program sequencing and branching are outside this block.

The instruction stream has no back-pressure. `instr_ready_o` is high at all times, so any beat with `instr_valid_i` high is consumed in that cycle. A cycle with valid low changes no state.

Top module: `bus_cpu_core`

## Requirements
- R1: While `rst_n` is low, the bus, all four registers, both operand latches and the carry flag are cleared to zero on each clock edge.
- R2: `instr_ready_o` is always 1. An instruction executes on the edge where `instr_valid_i` is 1, and its result is visible on the outputs after that edge. A cycle with `instr_valid_i` at 0 leaves the bus, the registers, the operand latches and the carry flag unchanged.
- R3: Instruction `00000` sets the bus to zero.
- R4: Instruction `10ooo` puts the ALU result for operation `ooo` on the bus. A is operand latch 0 and B is operand latch 1. The codes are: 000 A+B, 001 A-B, 010 A&B, 011 A|B, 100 A^B, 101 ~A, 110 A shifted left by one with a zero in the low bit, 111 A.
- R5: Addition and subtraction wrap modulo 2^DW. ADD sets the carry flag to the adder carry-out. SUB computes A+~B+1 and sets the carry flag to its carry-out, which is 1 when A≥B. Every other instruction leaves the carry flag unchanged.
- R6: Instruction `010rr` copies the bus into register `rr`, and the bus keeps its value.
- R7: Instruction `110rr` puts the contents of register `rr` on the bus.
- R8: Instruction `0110n` copies the bus into operand latch `n` (0 = A, 1 = B) and clears the bus.
- R9: Instruction `0111i` puts bit `i` on the bus, zero-extended to DW bits.
- R10: Every other encoding (`00001` to `00111` and `111xx`) leaves the bus, the registers, the operand latches and the carry flag unchanged.
- R11: `regs_o` carries register k in bits [k*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 5 | Instruction beat |
| instr_valid_i | input | 1 | Instruction beat is present |
| instr_ready_o | output | 1 | Always 1: the core never stalls |
| bus_o | output | DW | Current bus register value |
| regs_o | output | 4*DW | The four registers, packed |
| carry_o | output | 1 | Carry flag from the last ADD or SUB |

## Verification
The bench builds non-trivial operands out of the one-bit immediate by shifting and adding. This lets it reach a sum that wraps past the bus width; an adder with the carry dropped, or one that does not wrap, gives a wrong bus value or flag. It runs SUB both with A<B and with A≥B, so a core whose borrow sense is inverted reports the wrong carry. Non-arithmetic operations follow to show that the flag holds.

The hold encodings, the register load (which must keep the bus) and the operand load (which must clear it) are each followed at once by a bus check. A decoder that merges these cases gives a wrong bus. A beat with valid low carries an opcode that would change the bus, so a core that ignores the strobe is exposed. A mid-run reset is followed by a PASS A, which shows through the bus whether the operand latch was cleared.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int INSTR_W = 5;
  localparam int NREG    = 4;
  localparam int NOPND   = 2;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_NOTA = 3'd5,
    ALU_SHLA = 3'd6,
    ALU_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    K_CLEAR,
    K_ALU,
    K_STREG,
    K_RDREG,
    K_LDOPND,
    K_IMM,
    K_HOLD
  } instr_kind_e;

  typedef struct packed {
    instr_kind_e kind;
    alu_op_e     op;
    logic [1:0]  idx;
    logic        imm;
  } decoded_t;

endpackage

// File: rtl/cpu_decoder.sv
module cpu_decoder
  import cpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decoded_t           dec
);

  always_comb begin
    dec.kind = K_HOLD;
    dec.op   = alu_op_e'(instr[2:0]);
    dec.idx  = instr[1:0];
    dec.imm  = instr[0];
    if (instr == 5'b00000)            dec.kind = K_CLEAR;
    else if (instr[4:3] == 2'b10)     dec.kind = K_ALU;
    else if (instr[4:2] == 3'b010)    dec.kind = K_STREG;
    else if (instr[4:2] == 3'b110)    dec.kind = K_RDREG;
    else if (instr[4:1] == 4'b0110)   dec.kind = K_LDOPND;
    else if (instr[4:1] == 4'b0111)   dec.kind = K_IMM;
    else                              dec.kind = K_HOLD;
  end

endmodule

// File: rtl/cpu_ripple_add.sv
module cpu_ripple_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign cout = chain[W];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  output logic [DW-1:0]  result,
  output logic           arith,
  output logic           cout
);

  logic [DW-1:0] add_b;
  logic [DW-1:0] add_sum;
  logic          add_cin;
  logic          add_cout;

  assign add_b   = (op == ALU_SUB) ? ~opb : opb;
  assign add_cin = (op == ALU_SUB);

  cpu_ripple_add #(.W(DW)) u_add (
    .a    (opa),
    .b    (add_b),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    unique case (op)
      ALU_ADD,
      ALU_SUB:  result = add_sum;
      ALU_AND:  result = opa & opb;
      ALU_OR:   result = opa | opb;
      ALU_XOR:  result = opa ^ opb;
      ALU_NOTA: result = ~opa;
      ALU_SHLA: result = {opa[DW-2:0], 1'b0};
      default:  result = opa;
    endcase
  end

  assign arith = (op == ALU_ADD) || (op == ALU_SUB);
  assign cout  = add_cout;

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank #(
  parameter int DW    = 4,
  parameter int NR    = 4,
  localparam int AW   = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata,
  output logic [NR*DW-1:0] flat
);

  logic [DW-1:0] mem [NR];

  for (genvar k = 0; k < NR; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                       mem[k] <= '0;
      else if (we && waddr == AW'(k))   mem[k] <= wdata;
    end
    assign flat[k*DW +: DW] = mem[k];
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/bus_cpu_core.sv
module bus_cpu_core
  import cpu_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         instr_i,
  input  logic               instr_valid_i,
  output logic               instr_ready_o,
  output logic [DW-1:0]      bus_o,
  output logic [4*DW-1:0]    regs_o,
  output logic               carry_o
);

  localparam int RAW = $clog2(NREG);

  decoded_t      dec;
  logic [DW-1:0] bus_q;
  logic [DW-1:0] opnd_q [NOPND];
  logic          carry_q;
  logic [DW-1:0] alu_res;
  logic          alu_arith;
  logic          alu_cout;
  logic [DW-1:0] reg_rd;
  logic          reg_we;
  logic          fire;

  assign instr_ready_o = 1'b1;
  assign fire          = instr_valid_i;

  cpu_decoder u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  cpu_alu #(.DW(DW)) u_alu (
    .op     (dec.op),
    .opa    (opnd_q[0]),
    .opb    (opnd_q[1]),
    .result (alu_res),
    .arith  (alu_arith),
    .cout   (alu_cout)
  );

  assign reg_we = fire && (dec.kind == K_STREG);

  cpu_regbank #(.DW(DW), .NR(NREG)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .waddr (dec.idx[RAW-1:0]),
    .wdata (bus_q),
    .raddr (dec.idx[RAW-1:0]),
    .rdata (reg_rd),
    .flat  (regs_o)
  );

  // bus register: each instruction kind selects its next value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q <= '0;
    end else if (fire) begin
      unique case (dec.kind)
        K_CLEAR,
        K_LDOPND: bus_q <= '0;
        K_ALU:    bus_q <= alu_res;
        K_RDREG:  bus_q <= reg_rd;
        K_IMM:    bus_q <= {{(DW-1){1'b0}}, dec.imm};
        default:  bus_q <= bus_q;
      endcase
    end
  end

  for (genvar n = 0; n < NOPND; n++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (!rst_n)
        opnd_q[n] <= '0;
      else if (fire && dec.kind == K_LDOPND && dec.idx[0] == 1'(n))
        opnd_q[n] <= bus_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  carry_q <= 1'b0;
    else if (fire && dec.kind == K_ALU && alu_arith) carry_q <= alu_cout;
  end

  assign bus_o   = bus_q;
  assign carry_o = carry_q;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int DW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      instr_i,
  input logic            instr_valid_i,
  input logic            instr_ready_o,
  input logic [DW-1:0]   bus_o,
  input logic [4*DW-1:0] regs_o,
  input logic            carry_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (bus_o == '0 && regs_o == '0 && carry_o == 1'b0));

  // R2
  always_ready_chk: assert property (@(posedge clk) instr_ready_o == 1'b1);

  // R2
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> ($stable(bus_o) && $stable(regs_o) && $stable(carry_o)));

  // R3
  nop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i == 5'b00000) |=> bus_o == '0);

  // R6
  store_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i[4:2] == 3'b010) |=> $stable(bus_o));

  // R8
  opnd_load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i[4:1] == 4'b0110) |=> (bus_o == '0 && $stable(regs_o)));

  // R9
  immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i[4:1] == 4'b0111)
      |=> bus_o == {{(DW-1){1'b0}}, $past(instr_i[0])});

  // R10
  hold_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && (instr_i[4:2] == 3'b111 || (instr_i[4:3] == 2'b00 && instr_i != 5'b00000)))
      |=> ($stable(bus_o) && $stable(regs_o) && $stable(carry_o)));

  // R5
  carry_only_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && !(instr_i[4:3] == 2'b10 && instr_i[2:1] == 2'b00)) |=> $stable(carry_o));

endmodule

bind bus_cpu_core cpu_core_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .instr_ready_o (instr_ready_o),
  .bus_o         (bus_o),
  .regs_o        (regs_o),
  .carry_o       (carry_o)
);

// File: tb/sim_bus_cpu_core.sv
module sim_bus_cpu_core;

  localparam int DW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      instr_i = 5'b0;
  logic            instr_valid_i = 1'b0;
  logic            instr_ready_o;
  logic [DW-1:0]   bus_o;
  logic [4*DW-1:0] regs_o;
  logic            carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_cpu_core #(.DW(DW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .instr_ready_o (instr_ready_o),
    .bus_o         (bus_o),
    .regs_o        (regs_o),
    .carry_o       (carry_o)
  );

  // {instr, expected bus, expected carry}
  localparam int NV = 32;
  localparam logic [9:0] VEC [NV] = '{
    {5'b01111, 4'd1,  1'b0},  // R9 imm 1
    {5'b01100, 4'd0,  1'b0},  // R8 A=1
    {5'b01111, 4'd1,  1'b0},  // R9
    {5'b01101, 4'd0,  1'b0},  // R8 B=1
    {5'b10000, 4'd2,  1'b0},  // R4 ADD
    {5'b01100, 4'd0,  1'b0},  // A=2
    {5'b10110, 4'd4,  1'b0},  // R4 SHL
    {5'b01100, 4'd0,  1'b0},  // A=4
    {5'b10110, 4'd8,  1'b0},  // SHL
    {5'b01100, 4'd0,  1'b0},  // A=8
    {5'b10000, 4'd9,  1'b0},  // ADD 8+1
    {5'b01000, 4'd9,  1'b0},  // R6 r0=9, bus kept
    {5'b01100, 4'd0,  1'b0},  // A=9
    {5'b10000, 4'd10, 1'b0},  // ADD 9+1
    {5'b01101, 4'd0,  1'b0},  // B=10
    {5'b10000, 4'd3,  1'b1},  // R5 ADD 9+10 wraps, carry
    {5'b10001, 4'd15, 1'b0},  // R5 SUB 9-10 borrow
    {5'b10010, 4'd8,  1'b0},  // R4 AND
    {5'b10011, 4'd11, 1'b0},  // R4 OR
    {5'b10100, 4'd3,  1'b0},  // R4 XOR
    {5'b10101, 4'd6,  1'b0},  // R4 NOT A
    {5'b10111, 4'd9,  1'b0},  // R4 PASS
    {5'b00001, 4'd9,  1'b0},  // R10 hold
    {5'b11100, 4'd9,  1'b0},  // R10 hold 111xx
    {5'b11000, 4'd9,  1'b0},  // R7 r0 to bus
    {5'b01001, 4'd9,  1'b0},  // R6 r1=9
    {5'b00000, 4'd0,  1'b0},  // R3 clear
    {5'b11001, 4'd9,  1'b0},  // R7 r1
    {5'b01110, 4'd0,  1'b0},  // R9 imm 0
    {5'b01011, 4'd0,  1'b0},  // R6 r3=0
    {5'b11011, 4'd0,  1'b0},  // R7 r3
    {5'b10110, 4'd2,  1'b0}   // SHL 9 drops msb
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] ins, input logic vld);
    @(negedge clk);
    instr_i = ins;
    instr_valid_i = vld;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 bus", 32'(bus_o), 32'd0);
    check("R1 regs", 32'(regs_o), 32'd0);
    check("R1 carry", 32'(carry_o), 32'd0);
    check("R2 ready", 32'(instr_ready_o), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:5], 1'b1);
      check($sformatf("R4/vector %0d bus", i), 32'(bus_o), 32'(VEC[i][4:1]));
      check($sformatf("R5/vector %0d carry", i), 32'(carry_o), 32'(VEC[i][0]));
    end

    // R11 packing: r0=9 r1=9 r2=0 r3=0
    check("R11 regs", 32'(regs_o), 32'h0099);

    // R5 SUB with A>=B sets carry; AND then leaves it
    step(5'b01101, 1'b1);            // B=2 (bus was 2)
    step(5'b10001, 1'b1);            // 9-2
    check("R5 sub bus", 32'(bus_o), 32'd7);
    check("R5 sub carry", 32'(carry_o), 32'd1);
    step(5'b10010, 1'b1);            // 9&2=0
    check("R5 carry kept", 32'(carry_o), 32'd1);
    check("R4 and", 32'(bus_o), 32'd0);

    // R2 valid low: PASS would give 9
    step(5'b10111, 1'b0);
    check("R2 idle bus", 32'(bus_o), 32'd0);
    check("R2 idle regs", 32'(regs_o), 32'h0099);

    // R1 mid-run reset clears everything including operand A
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid_i = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid bus", 32'(bus_o), 32'd0);
    check("R1 mid regs", 32'(regs_o), 32'd0);
    check("R1 mid carry", 32'(carry_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(5'b10111, 1'b1);
    check("R1 operand A cleared", 32'(bus_o), 32'd0);

    step(5'b00000, 1'b0);
    finish_run();
  end

endmodule